// File: doc/BRIEF.md
# Guarded External Reset Pulse Generator

This block produces the pulse that a watchdog expiry sends off-chip to reset other parts of the board. When a trigger arrives, the block drives its output to the asserted level for a programmed number of microsecond ticks. It then returns the output to the idle level. A single 32-bit settings word holds three things: the pulse length in its low 20 bits, the output polarity, and the pad drive style.

The length is written directly. Polarity and drive style are different: they only change when the top byte of a write carries one of four command codes. Any other top byte leaves both settings alone, even though the length is still taken from the same write. This stops a careless store to the length from also flipping the pad behaviour.

A one-cycle `tick` strobe from an external 1 MHz divider sets the time base. `pulse_oe` lets the output sit on a shared open-drain reset net.

Top module: `ext_reset_pulser`

## Requirements
- R1: After synchronous reset the block is in this state:
  - `rd_data` reads 0x000000FF: length field 0xFF, active-low, open-drain.
  - `pulse_out` is 1.
  - `pulse_oe` is 0.
- R2: A write whose bits [31:24] equal 0xA5 sets the polarity to active-high, and a write whose bits [31:24] equal 0x5A sets it to active-low. The polarity reads back on bit 31 (1 = active-high) from the cycle after the write.
- R3: A write whose bits [31:24] equal 0xA8 sets push-pull drive, and a write whose bits [31:24] equal 0x8A sets open-drain drive. The drive style reads back on bit 30 (1 = push-pull).
- R4: A write with any other value in bits [31:24] leaves bits 31 and 30 unchanged. Every write, whatever its top byte, loads bits [19:0] into the length field.
- R5: Read bits [29:20] are always zero, and bits [19:0] return the stored length.
- R6: A trigger sampled while idle starts a pulse.
  - With a stored length N, the pulse ends at the clock edge that samples the (N+1)-th tick after the start edge.
  - A tick sampled on the start edge is not counted.
  - `pulse_out` follows the internal pulse state one clock later.
- R7: A trigger sampled while a pulse is in progress is ignored. The pulse is neither restarted nor lengthened.
- R8: During a pulse `pulse_out` drives 1 when the polarity is active-high and 0 when it is active-low. When idle it drives the opposite level.
- R9: In push-pull mode `pulse_oe` is 1. In open-drain mode `pulse_oe` is 1 only while a pulse is in progress and the driven level is 0.
- R10: The length is captured when a pulse starts. A write to the length during a pulse does not change that pulse, and ticks received while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the settings word |
| wr_data | input | 32 | Settings write data; top byte is the command field |
| rd_data | output | 32 | Settings read-back |
| trigger | input | 1 | Starts a pulse when idle |
| tick | input | 1 | One-cycle 1 MHz time-base strobe |
| pulse_out | output | 1 | Reset pulse level |
| pulse_oe | output | 1 | Output enable for the pad |

## Verification
The bench tries the settings word with the following writes, each with a different top byte:
- the four command codes, which show that each code moves only its own bit;
- the null byte, which shows that the length loads while the mode holds;
- an unrelated byte, which also shows that the length loads while the mode holds.

Pulses are run in all four polarity and drive combinations, so that the output level and enable are seen in each. Three timing cases are also covered:
- a zero length, which separates the N+1 counting from an off-by-one;
- a second trigger in mid-pulse, which separates ignoring it from restarting;
- a length rewrite during a pulse, which separates capture at start from live use.

A behavioural model is compared with all three outputs on every clock.

// File: rtl/erp_pkg.sv
package erp_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] CMD_HIGH  = 8'hA5;
  localparam logic [7:0] CMD_LOW   = 8'h5A;
  localparam logic [7:0] CMD_PUSH  = 8'hA8;
  localparam logic [7:0] CMD_DRAIN = 8'h8A;

  typedef struct packed {
    logic act_high;
    logic push_pull;
  } erp_mode_t;

  // Apply a command byte to the current mode; unknown bytes keep it.
  function automatic erp_mode_t apply_cmd(input erp_mode_t cur, input logic [7:0] cmd);
    erp_mode_t nxt;
    nxt = cur;
    case (cmd)
      CMD_HIGH:  nxt.act_high  = 1'b1;
      CMD_LOW:   nxt.act_high  = 1'b0;
      CMD_PUSH:  nxt.push_pull = 1'b1;
      CMD_DRAIN: nxt.push_pull = 1'b0;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/erp_cfg_reg.sv
module erp_cfg_reg
  import erp_pkg::*;
#(
  parameter int DUR_W = 20,
  parameter logic [DUR_W-1:0] DUR_RST = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_cmd,
  input  logic [DUR_W-1:0]  wr_dur,
  output erp_mode_t         mode,
  output logic [DUR_W-1:0]  dur,
  output logic [WORD_W-1:0] rd_data
);
  localparam int GAP_W = WORD_W - 2 - DUR_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      dur  <= DUR_RST;
      mode <= '{act_high: 1'b0, push_pull: 1'b0};
    end else if (wr_en) begin
      dur  <= wr_dur;
      mode <= apply_cmd(mode, wr_cmd);
    end
  end

  generate
    if (GAP_W > 0) begin : g_gap
      assign rd_data = {mode.act_high, mode.push_pull, {GAP_W{1'b0}}, dur};
    end else begin : g_nogap
      assign rd_data = {mode.act_high, mode.push_pull, dur};
    end
  endgenerate
endmodule

// File: rtl/erp_pulse_timer.sv
module erp_pulse_timer #(
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigger,
  input  logic             tick,
  input  logic [DUR_W-1:0] dur_load,
  output logic             busy,
  output logic [DUR_W-1:0] remaining
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (!busy) begin
      if (trigger) begin
        busy      <= 1'b1;
        remaining <= dur_load;
      end
    end else if (tick) begin
      if (remaining == '0) busy <= 1'b0;
      else                 remaining <= remaining - 1'b1;
    end
  end
endmodule

// File: rtl/erp_pad_drive.sv
module erp_pad_drive
  import erp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      busy,
  input  erp_mode_t mode,
  output logic      pulse_out,
  output logic      pulse_oe
);
  logic level;
  assign level = busy ? mode.act_high : ~mode.act_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= 1'b1;
      pulse_oe  <= 1'b0;
    end else begin
      pulse_out <= level;
      pulse_oe  <= mode.push_pull | (busy & ~level);
    end
  end
endmodule

// File: rtl/ext_reset_pulser.sv
module ext_reset_pulser
  import erp_pkg::*;
#(
  parameter int DUR_W = 20,
  parameter logic [DUR_W-1:0] DUR_RST = 'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        trigger,
  input  logic        tick,
  output logic        pulse_out,
  output logic        pulse_oe
);
  erp_mode_t        mode;
  logic [DUR_W-1:0] dur;
  logic             busy;
  logic [DUR_W-1:0] remaining;

  generate
    if (DUR_W < 24) begin : g_spare
      logic unused_wr_bits;
      assign unused_wr_bits = ^wr_data[23:DUR_W];
    end
  endgenerate

  erp_cfg_reg #(.DUR_W(DUR_W), .DUR_RST(DUR_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_cmd(wr_data[31:24]), .wr_dur(wr_data[DUR_W-1:0]),
    .mode(mode), .dur(dur), .rd_data(rd_data)
  );

  erp_pulse_timer #(.DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst(rst), .trigger(trigger), .tick(tick),
    .dur_load(dur), .busy(busy), .remaining(remaining)
  );

  erp_pad_drive u_pad (
    .clk(clk), .rst(rst), .busy(busy), .mode(mode),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );
endmodule

// File: rtl/ext_reset_pulser_chk.sv
module ext_reset_pulser_chk #(
  parameter int DUR_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             trigger,
  input logic             pulse_out,
  input logic             pulse_oe,
  input logic             busy,
  input logic [DUR_W-1:0] remaining
);
  p_reset_len_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data[19:0] == 20'hFF);

  p_high_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[31:24] == 8'hA5) |=> rd_data[31]);

  p_drain_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[31:24] == 8'h8A) |=> !rd_data[30]);

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[31:24] != 8'hA5 && wr_data[31:24] != 8'h5A &&
     wr_data[31:24] != 8'hA8 && wr_data[31:24] != 8'h8A)
      |=> $stable(rd_data[31:30]));

  p_gap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rd_data[29:20] == 10'd0);

  p_no_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && trigger) |=> remaining <= $past(remaining));

  p_pp_oe_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_data[30])) |-> pulse_oe);

  p_od_low_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_data[30]) && pulse_oe) |-> !pulse_out);
endmodule

bind ext_reset_pulser ext_reset_pulser_chk #(.DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .trigger(trigger), .pulse_out(pulse_out), .pulse_oe(pulse_oe),
  .busy(busy), .remaining(remaining)
);

// File: tb/ext_reset_pulser_test.sv
module ext_reset_pulser_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        trigger = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] rd_data;
  logic        pulse_out, pulse_oe;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    tick_run = 1'b0;
  int    tdiv = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // reference model state
  logic [19:0] m_dur = 20'hFF;
  logic        m_high = 1'b0, m_pp = 1'b0, m_busy = 1'b0;
  logic        m_out = 1'b1, m_oe = 1'b0;
  int          m_left = 0;

  always #4 clk = ~clk;

  ext_reset_pulser uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .trigger(trigger), .tick(tick), .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    logic lvl;
    cycles++;
    if (rst) begin
      m_dur = 20'hFF; m_high = 0; m_pp = 0; m_busy = 0; m_left = 0;
      m_out = 1; m_oe = 0;
    end else begin
      lvl   = m_busy ? m_high : !m_high;
      m_out = lvl;
      m_oe  = m_pp || (m_busy && !lvl);
      if (!m_busy) begin
        if (trigger) begin m_busy = 1; m_left = int'(m_dur); end
      end else if (tick) begin
        if (m_left == 0) m_busy = 0;
        else m_left = m_left - 1;
      end
      if (wr_en) begin
        m_dur = wr_data[19:0];
        if (wr_data[31:24] == 8'hA5) m_high = 1;
        else if (wr_data[31:24] == 8'h5A) m_high = 0;
        else if (wr_data[31:24] == 8'hA8) m_pp = 1;
        else if (wr_data[31:24] == 8'h8A) m_pp = 0;
      end
    end
    cmp_on = 1'b1;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check({phase, " rd_data"}, rd_data, {m_high, m_pp, 10'd0, m_dur});
      check({phase, " pulse_out R8"}, {31'd0, pulse_out}, {31'd0, m_out});
      check({phase, " pulse_oe R9"}, {31'd0, pulse_oe}, {31'd0, m_oe});
    end
    if (tick_run) begin
      tdiv++;
      tick = (tdiv % 4 == 0);
    end else tick = 1'b0;
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!m_busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", rd_data, 32'h0000_00FF);
    check("R1 reset out", {31'd0, pulse_out}, 32'd1);
    check("R1 reset oe", {31'd0, pulse_oe}, 32'd0);

    phase = "R4"; wr(32'h0000_0003); check("R4 null byte", rd_data, 32'h0000_0003);
    wr(32'h77F_00005);
    check("R5 gap zero", rd_data, 32'h0000_0005);
    phase = "R2"; wr(32'hA500_0003); check("R2 high", rd_data, 32'h8000_0003);
    phase = "R4"; wr(32'h3300_0004); check("R4 keep high", rd_data, 32'h8000_0004);
    phase = "R2"; wr(32'h5A00_0003); check("R2 low", rd_data, 32'h0000_0003);
    phase = "R3"; wr(32'hA800_0003); check("R3 push", rd_data, 32'h4000_0003);
    wr(32'h8A00_0003); check("R3 drain", rd_data, 32'h0000_0003);

    phase = "R10"; tick_run = 1'b1;
    repeat (20) @(negedge clk);
    check("R10 idle ticks", {31'd0, pulse_out}, 32'd1);

    phase = "R6"; fire(); wait_idle();
    phase = "R7"; fire(); repeat (6) @(negedge clk); fire(); repeat (3) @(negedge clk); fire();
    wait_idle();
    phase = "R8"; wr(32'hA500_0002); wr(32'hA800_0002); fire(); wait_idle();
    phase = "R9"; wr(32'h8A00_0001); fire(); wait_idle();
    wr(32'h5A00_0004); fire(); wait_idle();
    phase = "R10"; wr(32'hA800_0006); fire(); repeat (5) @(negedge clk);
    wr(32'h0000_0000); wait_idle();
    phase = "R6"; fire(); wait_idle();
    check("R6 idle after zero-length", {31'd0, pulse_out}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    done = 1'b1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule